// File: doc/BRIEF.md
# Dual-Channel Serial Converter Output Interface

This block is the device-side serial output logic of a converter that samples two channels and holds two 12-bit results. A host pulls chip select low and toggles a serial clock. Each of the two data pins then carries a framed word: leading zeros, then the result MSB first, then trailing zeros. Chip select and the serial clock are sampled on a fast local clock, and their edges are found from registered copies.

The falling edge of chip select latches both results. It also turns both data pins on and puts the sampling stage into hold. After a fixed number of serial clock falling edges the hold is released on the next serial clock rising edge. If chip select stays low past one frame, pin A goes on to shift out channel B's result and pin B shifts out channel A's result, using the same framing. Each pin then turns off after two full frames, or earlier if chip select rises. Each pin has an enable output that shows when it would be driven.

Top module: `dual_adc_serial_tx`

## Requirements
- R1: After reset, and whenever chip select has been high at the previous local clock edge, both output enables are 0, both data outputs are 0 and `track` is 1.
- R2: One local clock after a chip select falling edge is seen, both enables are 1, both data outputs are 0 (first leading zero) and `track` is 0 (hold).
- R3: After k serial clock falling edges, for k = 0 and k = 1, both data outputs are 0 (two leading zeros).
- R4: After k falling edges, for k = 2 to 13, `dout_a` carries bit 13-k of the latched channel A result and `dout_b` carries bit 13-k of the latched channel B result, so the MSB comes first and the LSB is present after edge 13.
- R5: `track` stays 0 until 13 falling edges have occurred, and becomes 1 on the first serial clock rising edge after that.
- R6: With a 16-clock frame, both data outputs are 0 after edges 14 and 15 (two trailing zeros).
- R7: After k edges, for k = 16 to 31, `dout_a` carries the channel B word and `dout_b` carries the channel A word, with the same leading-zero, MSB-first and trailing-zero framing shifted by 16 edges.
- R8: After the 32nd falling edge both enables are 0 and both data outputs are 0, and further falling edges do not turn them on again.
- R9: A rising edge of chip select at any point in the frame makes both enables 0 one local clock later.
- R10: Serial clock edges while chip select is high have no effect, and every new frame starts again from the first leading zero.
- R11: The results are latched at the chip select falling edge. Changes on `res_a` or `res_b` during a frame do not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host, idles high |
| res_a | input | DW | Channel A conversion result |
| res_b | input | DW | Channel B conversion result |
| dout_a | output | 1 | Serial data on pin A, 0 when disabled |
| dout_b | output | 1 | Serial data on pin B, 0 when disabled |
| oe_a | output | 1 | Pin A drive enable, 0 means high impedance |
| oe_b | output | 1 | Pin B drive enable, 0 means high impedance |
| track | output | 1 | 1 = track, 0 = hold |

## Verification
The bench builds the block with a 12-bit result, two leading zeros and a 16-clock frame. With these values each frame has two trailing zeros, and the pin cutoff falls on the 32nd edge, so both the trailing-zero slots and the cross-channel read-out are covered. Frames of full length, truncated frames, and idle serial clock activity are each compared bit by bit against a model that builds the 32-bit sequence for each pin on its own.

// File: rtl/dual_adc_serial_tx.sv
module dual_adc_serial_tx #(
  parameter int DW    = 12,
  parameter int LZ    = 2,
  parameter int FRAME = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic [DW-1:0] res_a,
  input  logic [DW-1:0] res_b,
  output logic          dout_a,
  output logic          dout_b,
  output logic          oe_a,
  output logic          oe_b,
  output logic          track
);
  localparam int TZ  = FRAME - DW - LZ;
  localparam int TOT = 2 * FRAME;
  localparam int REL = LZ + DW - 1;
  localparam int CW  = $clog2(TOT + 1);

  logic           cs_q, sclk_q, act, trk_q;
  logic [CW-1:0]  cnt;
  logic [TOT-1:0] sh_a, sh_b;

  wire cs_fall = !cs_n && cs_q;
  wire sc_fall = !sclk && sclk_q;
  wire sc_rise = sclk && !sclk_q;
  wire done    = (cnt == CW'(TOT));

  wire [FRAME-1:0] fa = {{(FRAME-DW){1'b0}}, res_a} << TZ;
  wire [FRAME-1:0] fb = {{(FRAME-DW){1'b0}}, res_b} << TZ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      act    <= 1'b0;
      cnt    <= '0;
      sh_a   <= '0;
      sh_b   <= '0;
      trk_q  <= 1'b1;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (cs_n) begin
        act   <= 1'b0;
        cnt   <= '0;
        trk_q <= 1'b1;
      end else if (cs_fall) begin
        act   <= 1'b1;
        cnt   <= '0;
        sh_a  <= {fa, fb};
        sh_b  <= {fb, fa};
        trk_q <= 1'b0;
      end else if (act) begin
        if (sc_fall && !done) begin
          cnt  <= cnt + 1'b1;
          sh_a <= {sh_a[TOT-2:0], 1'b0};
          sh_b <= {sh_b[TOT-2:0], 1'b0};
        end
        if (sc_rise && cnt >= CW'(REL)) trk_q <= 1'b1;
      end
    end
  end

  assign oe_a   = act && !done;
  assign oe_b   = oe_a;
  assign dout_a = oe_a && sh_a[TOT-1];
  assign dout_b = oe_b && sh_b[TOT-1];
  assign track  = trk_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !oe_a && !oe_b && !dout_a && !dout_b && track); // R1
  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> oe_a && oe_b && !dout_a && !dout_b && !track); // R2
  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a && cnt < CW'(LZ)) |-> !dout_a && !dout_b); // R3
  AST_HOLD_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && cnt < CW'(REL)) |-> !track); // R5
  AST_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !oe_a && !oe_b); // R8
  AST_CS_RISE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> !oe_a && !oe_b); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && $past(act)) |-> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)); // R10
endmodule

// File: tb/dual_adc_serial_tx_bench.sv
module dual_adc_serial_tx_bench;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1;
  logic [11:0] res_a = '0, res_b = '0;
  logic dout_a, dout_b, oe_a, oe_b, track;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  typedef struct { string tag; logic oe; logic da; logic db; logic trk; } exp_t;
  exp_t exp_q[$];
  event smp;

  always #2 clk = ~clk;

  dual_adc_serial_tx u_dual_adc_serial_tx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .res_a(res_a), .res_b(res_b),
    .dout_a(dout_a), .dout_b(dout_b), .oe_a(oe_a), .oe_b(oe_b), .track(track));

  task automatic cmp(string tag, string what, logic act, logic expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, expv, $time);
    end
  endtask

  initial forever begin
    exp_t it;
    @(smp);
    it = exp_q.pop_front();
    cmp(it.tag, "oe_a", oe_a, it.oe);
    cmp(it.tag, "oe_b", oe_b, it.oe);
    cmp(it.tag, "dout_a", dout_a, it.da);
    cmp(it.tag, "dout_b", dout_b, it.db);
    cmp((it.tag == "R1" || it.tag == "R10") ? it.tag : "R5", "track", track, it.trk);
  end

  task automatic push(string tag, logic oe, logic da, logic db, logic trk);
    exp_t it;
    it.tag = tag; it.oe = oe; it.da = da; it.db = db; it.trk = trk;
    exp_q.push_back(it);
    -> smp;
    @(negedge clk);
  endtask

  function automatic string tag_of(int k);
    if (k == 0) return "R2";
    if (k < 2)  return "R3";
    if (k < 14) return "R4";
    if (k < 16) return "R6";
    if (k < 32) return "R7";
    return "R8";
  endfunction

  task automatic push_k(int k, logic [11:0] x, logic [11:0] y, logic trk, string tg);
    logic [31:0] sa, sb;
    logic oe;
    sa = {2'b00, x, 2'b00, 2'b00, y, 2'b00};
    sb = {2'b00, y, 2'b00, 2'b00, x, 2'b00};
    oe = (k < 32);
    push(tg, oe, oe ? sa[31-k] : 1'b0, oe ? sb[31-k] : 1'b0, trk);
  endtask

  task automatic wait2;
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(logic [11:0] x, logic [11:0] y, int nf, int chg);
    res_a = x; res_b = y;
    @(negedge clk); cs_n = 1'b0; wait2;
    push_k(0, x, y, 1'b0, tag_of(0));
    for (int k = 1; k <= nf; k++) begin
      if (k == chg) begin res_a = ~x; res_b = ~y; end
      @(negedge clk); sclk = 1'b0; wait2;
      push_k(k, x, y, k >= 14, (chg > 0 && k >= chg) ? "R11" : tag_of(k));
      @(negedge clk); sclk = 1'b1; wait2;
      if (k == 13) push_k(13, x, y, 1'b1, "R5");
    end
    @(negedge clk); cs_n = 1'b1; wait2;
    push("R9", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; wait2;
    push("R1", 1'b0, 1'b0, 1'b0, 1'b1);
    frame(12'hA5C, 12'h3F1, 32, 0);
    frame(12'hFFF, 12'h000, 36, 0);
    frame(12'h801, 12'h7FE, 14, 0);
    frame(12'h5A5, 12'hC3C, 6, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); sclk = 1'b0; wait2;
      push("R10", 1'b0, 1'b0, 1'b0, 1'b1);
      @(negedge clk); sclk = 1'b1; wait2;
    end
    frame(12'h123, 12'hFED, 20, 0);
    frame(12'h9B6, 12'h249, 32, 3);
    wait2;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule